// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counter channel of the kind used to build interval timers, rate generators and event counters. It holds a count register written a byte at a time, a counting element that decrements on each counting-clock tick, and a single output whose waveform depends on one of six operating modes. The counting element can run as a plain binary value or as four packed decimal digits.

The surrounding logic decodes the control word and the bus. It hands this channel the mode, the byte access type and the decimal-select flag as one write strobe, and the count bytes as a second strobe. The whole channel runs on one system clock. The falling edge of the counting clock is supplied as a one-cycle enable, `cnt_tick`. The gate pin is sampled on every system clock, so a rising gate edge between two ticks is held until the next tick uses it.

The current counting-element value is driven out continuously so that an outside latch can capture it. A pending-load flag shows that a written count has not yet reached the counting element.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low, the counting element reads 0, the pending-load flag is 0, and the channel is in mode 0 and does not count.
- R2: A mode write takes `mode_sel` as 0 to 5, with 6 and 7 acting as 2 and 3. From the next cycle it drives the output low for mode 0 and high for every other mode.
- R3: The access code selects how bytes are written. `acc_sel` 1 writes only the low byte and clears the high byte. Code 2 writes only the high byte and clears the low byte. Code 3 takes the low byte and then the high byte. Code 0 ignores byte writes, so nothing is loaded and the pending-load flag is unchanged.
- R4: Mode 0 works as follows. A complete count write drives the output low, and the next tick loads the count. The output rises on the tick that takes the element from 1 to 0 and stays high until a new mode or count is written, while the element keeps decrementing. A first byte of a two-byte write halts counting. A low gate holds the count.
- R5: Mode 1 works as follows. A count write alone does not start counting. The tick after a gate rising edge loads the count and drives the output low, and the output returns high when the element reaches 0. A further gate rise reloads the count. A count written during the pulse is used only at the next trigger.
- R6: Mode 2 works as follows. With count N the output is low for one tick out of every N: it is low while the element holds 1, and the next tick reloads N. A count written while running takes effect at the next reload. A low gate forces the output high at once and holds the count, and a gate rise restarts from the count register.
- R7: Mode 3 works as follows. The element falls by two per tick and the output toggles, with a reload, at the end of each half. For even N each half lasts N/2 ticks. For odd N the high half lasts (N+1)/2 ticks and the low half (N-1)/2 ticks.
- R8: Mode 4 works as follows. The output is high. The tick after a count write loads it. The output goes low for exactly one tick when the element passes from 1 to 0, only once per load, and a low gate stops the decrement.
- R9: Mode 5 works as follows. The count is loaded only on the tick after a gate rising edge, and a further rise reloads it. The output goes low for exactly one tick when the element passes from 1 to 0.
- R10: With `bcd_sel` = 0 the element counts in binary. With `bcd_sel` = 1 it counts as four decimal digits. A loaded 0 acts as 65536 in binary (0 decrements to 0xFFFF) and as 10000 in decimal (0 decrements to 0x9999).
- R11: The pending-load flag goes to 1 on the cycle after a complete count write and returns to 0 on the tick that copies the count into the counting element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | One-cycle enable marking a counting-clock falling edge |
| gate_in | input | 1 | Gate pin level, sampled each clock |
| mode_wr | input | 1 | Strobe that applies mode, access code and decimal select |
| mode_sel | input | 3 | Operating mode |
| acc_sel | input | 2 | Byte access code (0 none, 1 low, 2 high, 3 low then high) |
| bcd_sel | input | 1 | 1 selects decimal counting |
| byte_wr | input | 1 | Strobe for one count byte |
| byte_in | input | DATA_W | Count byte |
| out_pin | output | 1 | Channel output |
| count_val | output | 2*DATA_W | Current counting-element value |
| null_cnt | output | 1 | Written count not yet in the counting element |

## Verification
Checker properties watch, on every cycle, the output level after a mode write, the pending-load flag after a complete write, the single-tick low pulse of modes 2, 4 and 5, and the rule that a high mode-0 output stays high until the next write. The exact tick on which each mode loads, reloads and toggles cannot be written as a property, and the bench's scenarios show it. Those scenarios also cover the odd and even square-wave halves, the decimal borrow chain, zero treated as the maximum count, and the gate effects of inhibit, restart and retrigger.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      PM_TC_STOP   = 3'd0,
      PM_ONE_SHOT  = 3'd1,
      PM_RATE      = 3'd2,
      PM_SQUARE    = 3'd3,
      PM_SW_STROBE = 3'd4,
      PM_HW_STROBE = 3'd5
   } pit_mode_e;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_PAIR = 2'd3
   } pit_acc_e;

   // codes 6 and 7 alias the two periodic modes
   function automatic pit_mode_e fold_mode(input logic [2:0] sel);
      case (sel)
         3'd6:    fold_mode = PM_RATE;
         3'd7:    fold_mode = PM_SQUARE;
         default: fold_mode = pit_mode_e'(sel);
      endcase
   endfunction

endpackage

// File: rtl/pit_byte_loader.sv
module pit_byte_loader
   import pit_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic [1:0]            acc,
   input  logic                  byte_wr,
   input  logic [DATA_W-1:0]     byte_in,
   output logic [2*DATA_W-1:0]   cnt_reg,
   output logic                  done,
   output logic                  first
);

   logic              phase_q;
   logic [DATA_W-1:0] lo_stage;
   logic              wr_ok;

   assign wr_ok = byte_wr & ~restart;
   assign done  = wr_ok & ((acc == ACC_LO) | (acc == ACC_HI) |
                           ((acc == ACC_PAIR) & phase_q));
   assign first = wr_ok & (acc == ACC_PAIR) & ~phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= 1'b0;
         lo_stage <= '0;
         cnt_reg  <= '0;
      end else if (restart) begin
         phase_q  <= 1'b0;
      end else if (byte_wr) begin
         case (acc)
            ACC_LO:   cnt_reg <= {{DATA_W{1'b0}}, byte_in};
            ACC_HI:   cnt_reg <= {byte_in, {DATA_W{1'b0}}};
            ACC_PAIR: begin
               if (!phase_q) begin
                  lo_stage <= byte_in;
                  phase_q  <= 1'b1;
               end else begin
                  cnt_reg  <= {byte_in, lo_stage};
                  phase_q  <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pit_decrement.sv
module pit_decrement #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] val,
   input  logic             bcd,
   input  logic             by_two,
   output logic [CNT_W-1:0] res
);

   localparam int DIGITS = CNT_W / 4;

   logic [CNT_W-1:0]  bin_res;
   logic [CNT_W-1:0]  dec_res;
   logic [DIGITS-1:1] brw;

   assign bin_res = val - (by_two ? CNT_W'(2) : CNT_W'(1));

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_dig
         logic [4:0] need;
         logic [4:0] dig;
         logic [4:0] diff;
         assign dig = {1'b0, val[4*g +: 4]};
         if (g == 0) begin : g_low
            assign need = by_two ? 5'd2 : 5'd1;
         end else begin : g_up
            assign need = {4'd0, brw[g]};
         end
         assign diff = (dig < need) ? (dig + 5'd10 - need) : (dig - need);
         assign dec_res[4*g +: 4] = diff[3:0];
         if (g < DIGITS-1) begin : g_brw
            assign brw[g+1] = (dig < need);
         end
      end
   endgenerate

   assign res = bcd ? dec_res : bin_res;

endmodule

// File: rtl/pit_gate_sense.sv
module pit_gate_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   input  logic used,
   input  logic clear,
   output logic trig
);

   logic gate_q;
   logic pend_q;
   logic rise;

   assign rise = gate & ~gate_q;
   assign trig = pend_q | rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         gate_q <= gate;
         if (clear || used) pend_q <= 1'b0;
         else               pend_q <= pend_q | rise;
      end
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_tick,
   input  logic                gate_in,
   input  logic                mode_wr,
   input  logic [2:0]          mode_sel,
   input  logic [1:0]          acc_sel,
   input  logic                bcd_sel,
   input  logic                byte_wr,
   input  logic [DATA_W-1:0]   byte_in,
   output logic                out_pin,
   output logic [2*DATA_W-1:0] count_val,
   output logic                null_cnt
);

   localparam int CNT_W = 2 * DATA_W;

   generate
      if ((DATA_W % 4) != 0 || DATA_W < 4) begin : g_bad_width
         $error("pit_channel: DATA_W must be a multiple of 4, at least 4");
      end
   endgenerate

   pit_mode_e        mode_q;
   logic [1:0]       acc_q;
   logic             bcd_q;
   logic [CNT_W-1:0] cnt_reg;
   logic [CNT_W-1:0] ce;
   logic [CNT_W-1:0] dec_one;
   logic [CNT_W-1:0] dec_two;
   logic             out_q;
   logic             null_q;
   logic             load_pend;
   logic             run;
   logic             fired;
   logic             wr_done;
   logic             wr_first;
   logic             trig;
   logic             tick_go;
   logic             ce_one;
   logic             ce_two;
   logic             sq_term;
   logic             force_hi;

   pit_byte_loader #(.DATA_W(DATA_W)) u_load (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (mode_wr),
      .acc     (acc_q),
      .byte_wr (byte_wr),
      .byte_in (byte_in),
      .cnt_reg (cnt_reg),
      .done    (wr_done),
      .first   (wr_first)
   );

   pit_decrement #(.CNT_W(CNT_W)) u_dec1 (
      .val (ce), .bcd (bcd_q), .by_two (1'b0), .res (dec_one)
   );

   pit_decrement #(.CNT_W(CNT_W)) u_dec2 (
      .val (ce), .bcd (bcd_q), .by_two (1'b1), .res (dec_two)
   );

   assign tick_go = cnt_tick & ~mode_wr & ~wr_done & ~wr_first;

   pit_gate_sense u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .gate  (gate_in),
      .used  (tick_go),
      .clear (mode_wr),
      .trig  (trig)
   );

   assign ce_one  = (ce == CNT_W'(1));
   assign ce_two  = (ce == CNT_W'(2));
   // odd counts end the high half at 1 and the low half at 3
   assign sq_term = ce[0] ? (out_q ? ce_one : (ce == CNT_W'(3))) : ce_two;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= PM_TC_STOP;
         acc_q     <= ACC_NONE;
         bcd_q     <= 1'b0;
         ce        <= '0;
         out_q     <= 1'b0;
         null_q    <= 1'b0;
         load_pend <= 1'b0;
         run       <= 1'b0;
         fired     <= 1'b1;
      end else if (mode_wr) begin
         mode_q    <= fold_mode(mode_sel);
         acc_q     <= acc_sel;
         bcd_q     <= bcd_sel;
         out_q     <= (fold_mode(mode_sel) != PM_TC_STOP);
         run       <= 1'b0;
         load_pend <= 1'b0;
         fired     <= 1'b1;
      end else if (wr_first) begin
         if (mode_q == PM_TC_STOP) run <= 1'b0;
      end else if (wr_done) begin
         null_q <= 1'b1;
         case (mode_q)
            PM_TC_STOP: begin
               load_pend <= 1'b1;
               run       <= 1'b0;
               out_q     <= 1'b0;
            end
            PM_SW_STROBE:        load_pend <= 1'b1;
            PM_RATE, PM_SQUARE:  if (!run) load_pend <= 1'b1;
            default: ;
         endcase
      end else if (tick_go) begin
         case (mode_q)
            PM_TC_STOP: begin
               if (load_pend) begin
                  ce <= cnt_reg; null_q <= 1'b0; load_pend <= 1'b0; run <= 1'b1;
               end else if (run && gate_in) begin
                  ce <= dec_one;
                  if (ce_one) out_q <= 1'b1;
               end
            end
            PM_ONE_SHOT: begin
               if (trig) begin
                  ce <= cnt_reg; null_q <= 1'b0; out_q <= 1'b0; run <= 1'b1;
               end else if (run) begin
                  ce <= dec_one;
                  if (ce_one) out_q <= 1'b1;
               end
            end
            PM_RATE: begin
               if (trig || load_pend) begin
                  ce <= cnt_reg; null_q <= 1'b0; out_q <= 1'b1;
                  run <= 1'b1; load_pend <= 1'b0;
               end else if (!gate_in) begin
                  out_q <= 1'b1;
               end else if (run) begin
                  if (ce_one) begin
                     ce <= cnt_reg; null_q <= 1'b0; out_q <= 1'b1;
                  end else begin
                     ce    <= dec_one;
                     out_q <= ~ce_two;
                  end
               end
            end
            PM_SQUARE: begin
               if (trig || load_pend) begin
                  ce <= cnt_reg; null_q <= 1'b0; out_q <= 1'b1;
                  run <= 1'b1; load_pend <= 1'b0;
               end else if (!gate_in) begin
                  out_q <= 1'b1;
               end else if (run) begin
                  if (sq_term) begin
                     ce <= cnt_reg; null_q <= 1'b0; out_q <= ~out_q;
                  end else begin
                     ce <= dec_two;
                  end
               end
            end
            PM_SW_STROBE, PM_HW_STROBE: begin
               out_q <= 1'b1;
               if ((mode_q == PM_SW_STROBE) ? load_pend : trig) begin
                  ce <= cnt_reg; null_q <= 1'b0; load_pend <= 1'b0;
                  run <= 1'b1; fired <= 1'b0;
               end else if (run && (gate_in || mode_q == PM_HW_STROBE)) begin
                  ce <= dec_one;
                  if (ce_one && !fired) begin
                     out_q <= 1'b0;
                     fired <= 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign force_hi  = ~gate_in & ((mode_q == PM_RATE) | (mode_q == PM_SQUARE));
   assign out_pin   = out_q | force_hi;
   assign count_val = ce;
   assign null_cnt  = null_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnt_tick,
   input logic       mode_wr,
   input logic [2:0] mode_sel,
   input logic       byte_wr,
   input logic       out_pin,
   input logic       null_cnt,
   input logic       wr_done,
   input logic [2:0] mode_q
);

   AST_MODE0_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_sel == 3'd0) |=> !out_pin);  // R2

   AST_MODE_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_sel != 3'd0) |=> out_pin);  // R2

   AST_NULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> null_cnt);  // R11

   AST_TC_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd0 && out_pin && !mode_wr && !byte_wr) |=> out_pin);  // R4

   AST_RATE_LOW_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd2 && !out_pin && cnt_tick && !mode_wr && !byte_wr) |=> out_pin);  // R6

   AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd4 || mode_q == 3'd5) && !out_pin && cnt_tick && !mode_wr && !byte_wr)
      |=> out_pin);  // R8

endmodule

bind pit_channel pit_channel_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_tick (cnt_tick),
   .mode_wr  (mode_wr),
   .mode_sel (mode_sel),
   .byte_wr  (byte_wr),
   .out_pin  (out_pin),
   .null_cnt (null_cnt),
   .wr_done  (wr_done),
   .mode_q   (mode_q)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        gate_in = 1'b1;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic [1:0]  acc_sel = 2'd0;
   logic        bcd_sel = 1'b0;
   logic        byte_wr = 1'b0;
   logic [7:0]  byte_in = 8'd0;
   logic        out_pin;
   logic [15:0] count_val;
   logic        null_cnt;

   int checks = 0;
   int errors = 0;
   int issued = 0;
   int served = 0;

   typedef struct {
      int    o;
      int    c;
      int    n;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   pit_channel u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_tick  (cnt_tick),
      .gate_in   (gate_in),
      .mode_wr   (mode_wr),
      .mode_sel  (mode_sel),
      .acc_sel   (acc_sel),
      .bcd_sel   (bcd_sel),
      .byte_wr   (byte_wr),
      .byte_in   (byte_in),
      .out_pin   (out_pin),
      .count_val (count_val),
      .null_cnt  (null_cnt)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor: pops expectations and compares on a falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (it.o >= 0 && out_pin !== it.o[0]) begin
               errors++;
               $display("FAIL %s out_pin actual %0b expected %0d", it.tag, out_pin, it.o);
            end
            if (it.c >= 0 && count_val !== it.c[15:0]) begin
               errors++;
               $display("FAIL %s count_val actual %h expected %h", it.tag, count_val, it.c[15:0]);
            end
            if (it.n >= 0 && null_cnt !== it.n[0]) begin
               errors++;
               $display("FAIL %s null_cnt actual %0b expected %0d", it.tag, null_cnt, it.n);
            end
            served++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
   end

   task automatic chk(input int o, input int c, input int n, input string tag);
      exp_t it;
      it.o = o; it.c = c; it.n = n; it.tag = tag;
      sb.push_back(it);
      issued++;
      wait (served == issued);
   endtask

   task automatic set_mode(input logic [2:0] m, input logic [1:0] a, input logic b);
      @(negedge clk);
      mode_wr = 1'b1; mode_sel = m; acc_sel = a; bcd_sel = b;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d);
      @(negedge clk);
      byte_wr = 1'b1; byte_in = d;
      @(negedge clk);
      byte_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt_tick = 1'b1;
         @(negedge clk);
         cnt_tick = 1'b0;
      end
   endtask

   task automatic gate_set(input logic v);
      @(negedge clk);
      gate_in = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(0, 16'h0000, 0, "R1 reset state");

      // mode 0, low then high byte
      set_mode(3'd0, 2'd3, 1'b0);
      chk(0, -1, -1, "R2 mode 0 drives low");
      wr_byte(8'd5);
      wr_byte(8'd0);
      chk(0, -1, 1, "R11 flag set after write");
      ticks(1);
      chk(0, 5, 0, "R11 flag cleared on load");
      ticks(4);
      chk(0, 1, -1, "R4 not yet terminal");
      ticks(1);
      chk(1, 0, -1, "R4 terminal count");
      ticks(2);
      chk(1, 16'hFFFE, -1, "R4 keeps decrementing");
      wr_byte(8'd3);
      ticks(2);
      chk(1, 16'hFFFE, -1, "R4 first byte halts");
      wr_byte(8'd0);
      chk(0, -1, 1, "R4 second byte rearms");
      ticks(1);
      chk(0, 3, 0, "R4 loaded");
      gate_set(1'b0);
      ticks(2);
      chk(0, 3, -1, "R4 gate low holds");
      gate_set(1'b1);
      ticks(3);
      chk(1, 0, -1, "R4 terminal after gate");

      // access codes
      set_mode(3'd0, 2'd2, 1'b0);
      wr_byte(8'h01);
      ticks(1);
      chk(0, 16'h0100, 0, "R3 high byte only");
      set_mode(3'd0, 2'd0, 1'b0);
      wr_byte(8'h55);
      chk(0, 16'h0100, 0, "R3 code 0 ignored");
      ticks(1);
      chk(0, 16'h0100, 0, "R3 code 0 loads nothing");

      // zero count, binary and decimal
      set_mode(3'd0, 2'd1, 1'b0);
      wr_byte(8'h00);
      ticks(2);
      chk(0, 16'hFFFF, 0, "R10 binary zero wraps");
      set_mode(3'd0, 2'd1, 1'b1);
      wr_byte(8'h10);
      ticks(1);
      chk(0, 16'h0010, 0, "R10 decimal load");
      ticks(1);
      chk(0, 16'h0009, -1, "R10 decimal borrow");
      ticks(9);
      chk(1, 0, -1, "R10 decimal terminal");
      ticks(1);
      chk(1, 16'h9999, -1, "R10 decimal zero wraps");

      // mode 1
      set_mode(3'd1, 2'd1, 1'b0);
      chk(1, -1, -1, "R2 mode 1 drives high");
      wr_byte(8'd3);
      ticks(2);
      chk(1, 16'h9999, 1, "R5 no start without trigger");
      gate_set(1'b0);
      gate_set(1'b1);
      ticks(1);
      chk(0, 3, 0, "R5 trigger starts pulse");
      ticks(2);
      chk(0, 1, -1, "R5 pulse continues");
      ticks(1);
      chk(1, 0, -1, "R5 pulse ends");
      gate_set(1'b0);
      gate_set(1'b1);
      ticks(1);
      chk(0, 3, -1, "R5 retrigger");
      ticks(1);
      wr_byte(8'd6);
      ticks(1);
      chk(0, 1, 1, "R5 new count not used mid pulse");
      ticks(1);
      chk(1, 0, -1, "R5 pulse ends on old count");
      gate_set(1'b0);
      gate_set(1'b1);
      ticks(1);
      chk(0, 6, 0, "R5 next trigger uses new count");

      // mode 2
      set_mode(3'd2, 2'd1, 1'b0);
      wr_byte(8'd4);
      ticks(1);
      chk(1, 4, 0, "R6 load");
      ticks(2);
      chk(1, 2, -1, "R6 high part");
      ticks(1);
      chk(0, 1, -1, "R6 low tick");
      ticks(1);
      chk(1, 4, -1, "R6 reload");
      wr_byte(8'd3);
      ticks(2);
      chk(1, 2, 1, "R6 new count waits");
      ticks(1);
      chk(0, 1, -1, "R6 low tick again");
      ticks(1);
      chk(1, 3, 0, "R6 reload uses new count");
      ticks(1);
      ticks(1);
      chk(0, 1, -1, "R6 low before gate drop");
      gate_set(1'b0);
      chk(1, 1, -1, "R6 gate low forces high");
      ticks(1);
      chk(1, 1, -1, "R6 gate low holds count");
      gate_set(1'b1);
      ticks(1);
      chk(1, 3, -1, "R6 gate rise restarts");

      // mode 3, odd then even
      set_mode(3'd3, 2'd1, 1'b0);
      wr_byte(8'd5);
      ticks(1);
      chk(1, 5, 0, "R7 load odd");
      ticks(2);
      chk(1, 1, -1, "R7 odd high part");
      ticks(1);
      chk(0, 5, -1, "R7 odd high lasts 3");
      ticks(1);
      chk(0, 3, -1, "R7 odd low part");
      ticks(1);
      chk(1, 5, -1, "R7 odd low lasts 2");
      set_mode(3'd3, 2'd1, 1'b0);
      wr_byte(8'd4);
      ticks(2);
      chk(1, 2, -1, "R7 even high part");
      ticks(1);
      chk(0, 4, -1, "R7 even high lasts 2");
      ticks(2);
      chk(1, 4, -1, "R7 even low lasts 2");
      set_mode(3'd3, 2'd1, 1'b1);
      wr_byte(8'h10);
      ticks(2);
      chk(1, 16'h0008, -1, "R10 decimal step of two");

      // mode 4
      set_mode(3'd4, 2'd1, 1'b0);
      wr_byte(8'd3);
      ticks(1);
      chk(1, 3, 0, "R8 load");
      ticks(2);
      chk(1, 1, -1, "R8 before strobe");
      ticks(1);
      chk(0, 0, -1, "R8 strobe low");
      ticks(1);
      chk(1, 16'hFFFF, -1, "R8 strobe one tick");
      ticks(2);
      chk(1, 16'hFFFD, -1, "R8 single strobe per load");
      gate_set(1'b0);
      ticks(2);
      chk(1, 16'hFFFD, -1, "R8 gate low inhibits");

      // mode 5
      set_mode(3'd5, 2'd1, 1'b0);
      wr_byte(8'd2);
      ticks(1);
      chk(1, 16'hFFFD, 1, "R9 waits for trigger");
      gate_set(1'b1);
      ticks(1);
      chk(1, 2, 0, "R9 trigger loads");
      ticks(1);
      gate_set(1'b0);
      gate_set(1'b1);
      ticks(1);
      chk(1, 2, -1, "R9 retrigger reloads");
      ticks(2);
      chk(0, 0, -1, "R9 strobe low");
      ticks(1);
      chk(1, 16'hFFFF, -1, "R9 strobe one tick");

      summary();
   end

endmodule